// File: doc/BRIEF.md
# Wormhole Output Port Arbiter

This block is the arbitration and multiplexing stage for one output port of a wormhole-routed switch. Every input offers the flit at the front of its queue: a data word, a head marker and a tail marker, plus a request bit that routing raises when the flit is bound for this output. When the output is free, the arbiter chooses one input whose request carries a head flit. It then locks the output to that input until the tail flit of that packet has crossed. Body and tail flits follow the head without further arbitration. Flits from different packets are never interleaved.

A credit counter tracks the free slots in the downstream buffer. No flit crosses while the count is zero. The lock holds while the packet waits for credits, and no other input can take the output in that time. The one-hot grant vector selects the output multiplexer and also tells the granted input to dequeue its front flit in that cycle. The transferred flit appears on the registered output one cycle later.

The controller has two states. ARB_IDLE means no packet owns the output. ARB_LOCKED means one input owns it. There are four transitions. CLAIM goes from ARB_IDLE to ARB_LOCKED when a multi-flit head is sent. SOLO stays in ARB_IDLE when a single-flit packet, with head and tail both set, is sent. STREAM stays in ARB_LOCKED while body flits move or the packet waits. RELEASE goes from ARB_LOCKED back to ARB_IDLE when the tail flit is sent.

Top module: `wh_out_arbiter`

## Requirements
- R1: Reset is asynchronous and active low. It clears out_valid at once. After release, the controller is in ARB_IDLE, the round-robin pointer is at input 0, and the credit count equals DEPTH, so DEPTH flits can be sent back to back before any credit is returned.
- R2: grant has at most one bit set. A grant bit is set only for an input whose in_req bit is set, and only in a cycle where the credit count is nonzero.
- R3: In ARB_IDLE, only an input with both in_req and in_head set can be granted. A requesting flit without the head marker gets no grant, and no flit appears on the output the next cycle.
- R4: Among competing head flits in ARB_IDLE, the winner is the first requesting input found by scanning upward from the pointer and wrapping past the highest index. After a packet finishes, the pointer becomes the winner's index plus one, modulo N_IN.
- R5: In ARB_LOCKED, only the owning input can be granted, until its flit with in_tail set is sent. Head requests from other inputs get no grant. A cycle in which the owner does not request sends nothing and keeps the lock.
- R6: When the credit count is zero, no grant is given. A locked packet stays locked, and once a credit returns, the same owner continues.
- R7: In the cycle after a grant, out_valid is 1 and out_data, out_head and out_tail carry the data and markers the granted input offered.
- R8: The credit count drops by one for each sent flit and rises by one for each cycle in which credit_ret is 1. A send and a return in the same cycle leave it unchanged.
- R9: A flit with both in_head and in_tail set is granted and released in one transfer. In the next cycle the output is free for any head, with the pointer moved past that input.
- R10: A cycle with no grant is followed by a cycle with out_valid at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_req | input | N_IN | Input's front flit is routed to this output |
| in_head | input | N_IN | Front flit of each input carries the head marker |
| in_tail | input | N_IN | Front flit of each input carries the tail marker |
| in_data | input | N_IN*FLIT_W | Front flit payloads; input i occupies bits [i*FLIT_W +: FLIT_W] |
| credit_ret | input | 1 | Downstream freed one buffer slot |
| grant | output | N_IN | One-hot dequeue strobe and multiplexer select for this cycle |
| out_valid | output | 1 | Registered output flit valid |
| out_head | output | 1 | Head marker of the output flit |
| out_tail | output | 1 | Tail marker of the output flit |
| out_data | output | FLIT_W | Payload of the output flit |

## Verification
The bench builds the block with N_IN = 4, FLIT_W = 8 and DEPTH = 2. With only two credits, a packet of two flits uses up the downstream buffer. This puts the cases of a locked packet stalled on zero credits, a credit returned in the same cycle as a send, and a tail flit waiting for its credit within a few cycles of each other. With four inputs, the pointer wraps from input 3 to input 0. It also allows heads on inputs both below and above the pointer, which shows the scan order. A reset in the middle of a packet shows that the lock, the pointer and the credit count all start over.

// File: rtl/wh_arb_pkg.sv
package wh_arb_pkg;

    typedef enum logic {
        ARB_IDLE   = 1'b0,
        ARB_LOCKED = 1'b1
    } arb_state_e;

endpackage

// File: rtl/wh_rr_pick.sv
module wh_rr_pick #(
    parameter int N_IN = 4,
    localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input  logic [N_IN-1:0] cand,
    input  logic [IW-1:0]   ptr,
    output logic            found,
    output logic [IW-1:0]   win_idx
);

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        for (int k = 0; k < N_IN; k++) begin
            int idx;
            idx = int'(ptr) + k;
            if (idx >= N_IN) begin
                idx = idx - N_IN;
            end
            if (!found && cand[idx]) begin
                found   = 1'b1;
                win_idx = IW'(idx);
            end
        end
    end

endmodule

// File: rtl/wh_credit_ctr.sv
module wh_credit_ctr #(
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] count,
    output logic          avail
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= CW'(DEPTH);
        end else begin
            unique case ({inc, dec})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign avail = (count != '0);

endmodule

// File: rtl/wh_out_arbiter.sv
module wh_out_arbiter
    import wh_arb_pkg::*;
#(
    parameter int N_IN   = 4,
    parameter int FLIT_W = 32,
    parameter int DEPTH  = 4,
    localparam int IW    = (N_IN > 1) ? $clog2(N_IN) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN-1:0]        in_req,
    input  logic [N_IN-1:0]        in_head,
    input  logic [N_IN-1:0]        in_tail,
    input  logic [N_IN*FLIT_W-1:0] in_data,
    input  logic                   credit_ret,
    output logic [N_IN-1:0]        grant,
    output logic                   out_valid,
    output logic                   out_head,
    output logic                   out_tail,
    output logic [FLIT_W-1:0]      out_data
);

    arb_state_e      state_q, state_d;
    logic [IW-1:0]   owner_q, owner_d;
    logic [IW-1:0]   ptr_q, ptr_d;
    logic [N_IN-1:0] head_cand;
    logic            win_found;
    logic [IW-1:0]   win_idx;
    logic [IW-1:0]   sel_idx;
    logic            xfer;
    logic            sel_tail;
    logic            credit_ok;
    logic [CW-1:0]   credits_q;
    logic [FLIT_W-1:0] lane [N_IN];

    function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] idx);
        if (int'(idx) == N_IN - 1) begin
            return '0;
        end
        return idx + 1'b1;
    endfunction

    genvar g;
    generate
        for (g = 0; g < N_IN; g++) begin : g_lane
            assign lane[g] = in_data[g*FLIT_W +: FLIT_W];
        end
    endgenerate

    assign head_cand = in_req & in_head;

    wh_rr_pick #(.N_IN(N_IN)) u_pick (
        .cand    (head_cand),
        .ptr     (ptr_q),
        .found   (win_found),
        .win_idx (win_idx)
    );

    wh_credit_ctr #(.DEPTH(DEPTH)) u_credit (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (credit_ret),
        .dec   (xfer),
        .count (credits_q),
        .avail (credit_ok)
    );

    // State register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    // Next-state process: CLAIM, SOLO, STREAM, RELEASE
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (xfer && !sel_tail) begin
                    state_d = ARB_LOCKED;
                    owner_d = win_idx;
                end else if (xfer) begin
                    ptr_d = next_idx(win_idx);
                end
            end
            ARB_LOCKED: begin
                if (xfer && sel_tail) begin
                    state_d = ARB_IDLE;
                    ptr_d   = next_idx(owner_q);
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    // Output process: select, transfer and grant
    always_comb begin
        sel_idx = owner_q;
        xfer    = 1'b0;
        unique case (state_q)
            ARB_IDLE: begin
                sel_idx = win_idx;
                xfer    = win_found && credit_ok;
            end
            ARB_LOCKED: begin
                sel_idx = owner_q;
                xfer    = in_req[owner_q] && credit_ok;
            end
            default: begin
                sel_idx = owner_q;
                xfer    = 1'b0;
            end
        endcase
        sel_tail = in_tail[sel_idx];
        grant    = '0;
        if (xfer) begin
            grant[sel_idx] = 1'b1;
        end
    end

    // Link register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_head  <= 1'b0;
            out_tail  <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= xfer;
            if (xfer) begin
                out_head <= in_head[sel_idx];
                out_tail <= sel_tail;
                out_data <= lane[sel_idx];
            end
        end
    end

endmodule

// File: rtl/wh_out_arbiter_chk.sv
module wh_out_arbiter_chk
    import wh_arb_pkg::*;
#(
    parameter int N_IN = 4,
    parameter int CW   = 3,
    localparam int IW  = (N_IN > 1) ? $clog2(N_IN) : 1
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N_IN-1:0] in_req,
    input logic [N_IN-1:0] in_head,
    input logic            credit_ret,
    input logic [N_IN-1:0] grant,
    input logic            out_valid,
    input arb_state_e      state,
    input logic [IW-1:0]   owner,
    input logic [CW-1:0]   credits
);

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~in_req) == '0);

    // R6
    no_credit_send_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (credits == '0) |-> (grant == '0));

    // R3
    idle_head_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_IDLE && grant != '0) |-> ((grant & in_head) != '0));

    // R5
    lock_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ARB_LOCKED) |-> ((grant & ~(N_IN'(1) << owner)) == '0));

    // R7
    out_follows_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0) |=> out_valid);

    // R10
    idle_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0) |=> !out_valid);

    // R8
    credit_spend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !credit_ret) |=> (credits == $past(credits) - 1'b1));

    // R8
    credit_gain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && credit_ret) |=> (credits == $past(credits) + 1'b1));

endmodule

bind wh_out_arbiter wh_out_arbiter_chk #(.N_IN(N_IN), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_req     (in_req),
    .in_head    (in_head),
    .credit_ret (credit_ret),
    .grant      (grant),
    .out_valid  (out_valid),
    .state      (state_q),
    .owner      (owner_q),
    .credits    (credits_q)
);

// File: tb/sim_wh_out_arbiter.sv
`timescale 1ns/1ps
module sim_wh_out_arbiter;

    localparam int N  = 4;
    localparam int W  = 8;
    localparam int NV = 21;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [N-1:0]   in_req = '0, in_head = '0, in_tail = '0;
    logic [N*W-1:0] in_data = '0;
    logic           credit_ret = 1'b0;
    logic [N-1:0]   grant;
    logic           out_valid, out_head, out_tail;
    logic [W-1:0]   out_data;

    int n_chk = 0;
    int n_fail = 0;

    wh_out_arbiter #(.N_IN(N), .FLIT_W(W), .DEPTH(2)) u0 (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_head(in_head),
        .in_tail(in_tail), .in_data(in_data), .credit_ret(credit_ret),
        .grant(grant), .out_valid(out_valid), .out_head(out_head),
        .out_tail(out_tail), .out_data(out_data)
    );

    always #10 clk = ~clk;

    // fields: req[16:13] head[12:9] tail[8:5] credit[4] expected grant[3:0]
    localparam logic [16:0] TBL [NV] = '{
        {4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000},
        {4'b0010, 4'b0000, 4'b0000, 1'b0, 4'b0000},
        {4'b1010, 4'b1010, 4'b0000, 1'b0, 4'b0010},
        {4'b1010, 4'b1000, 4'b0000, 1'b0, 4'b0010},
        {4'b1010, 4'b1000, 4'b0010, 1'b0, 4'b0000},
        {4'b1010, 4'b1000, 4'b0010, 1'b1, 4'b0000},
        {4'b1010, 4'b1000, 4'b0010, 1'b0, 4'b0010},
        {4'b1001, 4'b1001, 4'b1001, 1'b1, 4'b0000},
        {4'b1001, 4'b1001, 4'b1001, 1'b0, 4'b1000},
        {4'b0001, 4'b0001, 4'b0001, 1'b1, 4'b0000},
        {4'b0001, 4'b0001, 4'b0001, 1'b1, 4'b0001},
        {4'b0101, 4'b0101, 4'b0000, 1'b1, 4'b0100},
        {4'b0001, 4'b0001, 4'b0000, 1'b0, 4'b0000},
        {4'b0101, 4'b0001, 4'b0000, 1'b0, 4'b0100},
        {4'b0101, 4'b0001, 4'b0100, 1'b1, 4'b0000},
        {4'b0101, 4'b0001, 4'b0100, 1'b1, 4'b0100},
        {4'b0001, 4'b0001, 4'b0000, 1'b1, 4'b0001},
        {4'b0001, 4'b0000, 4'b0001, 1'b0, 4'b0001},
        {4'b0000, 4'b0000, 4'b0000, 1'b1, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 1'b1, 4'b0000},
        {4'b0000, 4'b0000, 4'b0000, 1'b0, 4'b0000}
    };

    localparam string TAGS [NV] = '{
        "R10", "R3", "R4", "R5", "R6", "R6", "R5", "R8", "R9", "R8", "R9",
        "R4", "R5", "R5", "R6", "R5", "R4", "R5", "R10", "R8", "R10"
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input logic [N-1:0] rq, input logic [N-1:0] hd,
                         input logic [N-1:0] tl, input logic cr, input int step);
        in_req = rq;
        in_head = hd;
        in_tail = tl;
        credit_ret = cr;
        for (int i = 0; i < N; i++) begin
            in_data[i*W +: W] = W'((i << 5) | step);
        end
    endtask

    function automatic int idx_of(input logic [N-1:0] oh);
        for (int i = 0; i < N; i++) begin
            if (oh[i]) return i;
        end
        return 0;
    endfunction

    // check the registered output against the previous cycle's grant (R7, R10)
    task automatic chk_out(input logic [N-1:0] pg, input logic [N-1:0] ph,
                           input logic [N-1:0] pt, input int pstep);
        int i;
        chk(out_valid == (pg != '0), (pg != '0) ? "R7" : "R10", "out_valid",
            out_valid, (pg != '0));
        if (pg != '0) begin
            i = idx_of(pg);
            chk(out_data == W'((i << 5) | pstep), "R7", "out_data",
                out_data, (i << 5) | pstep);
            chk(out_head == ph[i], "R7", "out_head", out_head, ph[i]);
            chk(out_tail == pt[i], "R7", "out_tail", out_tail, pt[i]);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [N-1:0] pg, ph, pt;
        int pstep;
        repeat (3) @(negedge clk);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        @(negedge clk);
        rst_n = 1'b1;
        pg = '0; ph = '0; pt = '0; pstep = 0;

        for (int k = 0; k < NV; k++) begin
            logic [16:0] v;
            @(negedge clk);
            v = TBL[k];
            drive(v[16:13], v[12:9], v[8:5], v[4], k);
            #1;
            chk(grant == v[3:0], TAGS[k], "grant", grant, v[3:0]);
            chk($countones(grant) <= 1, "R2", "grant one-hot", grant, 0);
            chk_out(pg, ph, pt, pstep);
            pg = v[3:0]; ph = v[12:9]; pt = v[8:5]; pstep = k;
        end

        // Reset in the middle of a packet (R1)
        @(negedge clk);
        drive(4'b0100, 4'b0100, 4'b0000, 1'b0, 21);
        #1;
        chk(grant == 4'b0100, "R4", "grant from pointer 1", grant, 4'b0100);
        @(negedge clk);
        rst_n = 1'b0;
        drive(4'b0000, 4'b0000, 4'b0000, 1'b0, 22);
        #1;
        chk(out_valid == 1'b0, "R1", "out_valid cleared by reset", out_valid, 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // Pointer back at 0, full credits: two sends, third blocked (R1, R8)
        @(negedge clk);
        drive(4'b0011, 4'b0011, 4'b0011, 1'b0, 23);
        #1;
        chk(grant == 4'b0001, "R1", "pointer restarts at input 0", grant, 4'b0001);
        chk(out_valid == 1'b0, "R1", "no output after reset", out_valid, 0);
        @(negedge clk);
        drive(4'b0011, 4'b0011, 4'b0011, 1'b0, 24);
        #1;
        chk(grant == 4'b0010, "R9", "next head after single flit", grant, 4'b0010);
        chk_out(4'b0001, 4'b0011, 4'b0011, 23);
        @(negedge clk);
        drive(4'b0011, 4'b0011, 4'b0011, 1'b0, 25);
        #1;
        chk(grant == 4'b0000, "R8", "credits exhausted after DEPTH sends", grant, 0);
        chk_out(4'b0010, 4'b0011, 4'b0011, 24);
        @(negedge clk);
        drive(4'b0000, 4'b0000, 4'b0000, 1'b0, 26);
        #1;
        chk_out(4'b0000, 4'b0000, 4'b0000, 25);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule